// File: doc/BRIEF.md
# Two-Source Interrupt Dispatcher with Level Mask

The block decides, once per completed instruction, whether one of two interrupt sources should preempt the running program: a serial transmitter that reports its data register empty, and a periodic interval timer driven by an instruction-step counter. Each source carries a 3-bit level taken from its own priority byte. The higher of the pending levels is compared with the 3-bit mask held in the status word, and the request is taken only when it is strictly above that mask.

When a request is taken, a small sequencer saves the status word and then the return address on a downward-growing stack, one 16-bit word per cycle. It then hands the core a new program counter from an external vector lookup, together with the updated stack pointer. A return request reverses the process: the return address is read back first, the status word second, and the restored values and the stack pointer are handed back. While a handler is active, no further request is taken.

The core supplies the status word, the stack pointer, the program counter and a strobe at each instruction boundary. It also supplies a flag for each source saying whether that source has a usable vector entry. The block drives the memory word requests and the register reload strobes.

Top module: `intr_dispatch`

## Requirements
- R1: After reset the block issues no memory request and no reload strobe, reports no active handler and is not busy, and the transmitter empty flag starts set.
- R2: The level of a source is bits 6:4 of its priority byte and the mask is bits 10:8 of `sr_i`; a request is taken only when the winning level is strictly greater than the mask, so an equal level is blocked.
- R3: When both sources are candidates, the higher level wins; on equal levels the serial source wins. `vec_sel_o` reads 0 for serial and 1 for timer.
- R4: The serial source is pending only while bit 7 of `scr_i` and the transmitter empty flag are both set.
- R5: A pulse on `tdr_wr_i` clears the empty flag; it is set again by the second following boundary strobe and is first seen by arbitration at the strobe after that.
- R6: The step counter advances on every boundary strobe and the timer is pending while the count is greater than or equal to `period_i`; only acceptance of a timer request clears the count, so a blocked request stays pending.
- R7: Acceptance at a strobe writes `sr_i` to SP-2 one cycle later and the PC to SP-4 the cycle after that. In the next cycle, `pc_load_o` presents `vec_tgt_i` on `pc_o` and `sp_o` = SP-4. Each word is big-endian, with the high byte at the lower address.
- R8: A source whose `vec_ok_i` bit is clear (bit 0 serial, bit 1 timer) is never dispatched, and the other source may still win.
- R9: While `in_handler_o` is set, a boundary strobe without `rti_i` starts no entry sequence.
- R10: A strobe with `rti_i` while a handler is active reads the PC from SP and then the status word from SP+2. In the following cycle it raises `pc_load_o` and `sr_load_o` with those values and `sp_o` = SP+4, and clears `in_handler_o`.
- R11: Arbitration takes place only on `step_i`; with requests pending and no strobe, nothing is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Instruction-boundary strobe |
| rti_i | input | 1 | The finishing instruction is a return from interrupt |
| sr_i | input | 16 | Current status word |
| pri_ser_i | input | 8 | Serial priority byte |
| pri_tmr_i | input | 8 | Timer priority byte |
| scr_i | input | 8 | Serial control byte |
| tdr_wr_i | input | 1 | Write to the transmit data register |
| period_i | input | 12 | Timer period in boundary strobes |
| vec_ok_i | input | 2 | Vector entry present per source |
| vec_tgt_i | input | 16 | Handler address for the source on `vec_sel_o` |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | Return address |
| mem_rdata_i | input | 16 | Read data for the current read request |
| vec_sel_o | output | 1 | Source being dispatched |
| mem_wr_o | output | 1 | Word write request |
| mem_rd_o | output | 1 | Word read request |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| pc_load_o | output | 1 | Load `pc_o` into the PC |
| pc_o | output | 16 | New program counter |
| sr_load_o | output | 1 | Load `sr_o` into the status word |
| sr_o | output | 16 | Restored status word |
| sp_load_o | output | 1 | Load `sp_o` into the stack pointer |
| sp_o | output | 16 | New stack pointer |
| in_handler_o | output | 1 | A handler is active |
| busy_o | output | 1 | Sequencer is stacking or unstacking |

## Verification
A wrong level extraction, mask comparison or tie rule shows up in the first cycle after the strobe, as a write that should be absent or missing, or as the wrong `vec_sel_o`. The sweep over all level, mask and vector-presence combinations exposes it there. A stale stack pointer or a swapped word order shows up within two cycles, as a bad address or data on the memory port or on the reload outputs. Counter and empty-flag faults show up only as an acceptance one strobe early or late, so those paths are counted strobe by strobe.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NSRC    = 2;
  localparam int SRC_SER = 0;
  localparam int SRC_TMR = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_SR,
    ST_PUSH_PC,
    ST_LOAD,
    ST_POP_PC,
    ST_POP_SR,
    ST_FIN
  } seq_st_e;
endpackage

// File: rtl/txe_tracker.sv
module txe_tracker #(
  parameter int DELAY = 2,
  localparam int DW = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic tick_i,
  output logic empty_o
);
  logic          flag_q, flag_d;
  logic [DW-1:0] dly_q, dly_d;

  always_comb begin
    flag_d = flag_q;
    dly_d  = dly_q;
    if (wr_i) begin
      flag_d = 1'b0;
      dly_d  = DW'(DELAY);
    end else if (tick_i && dly_q != '0) begin
      dly_d = dly_q - DW'(1);
      if (dly_q == DW'(1)) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
      dly_q  <= '0;
    end else begin
      flag_q <= flag_d;
      dly_q  <= dly_d;
    end
  end

  assign empty_o = flag_q;
endmodule

// File: rtl/step_timer.sv
module step_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [CW-1:0] period_i,
  output logic          pend_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) cnt_d = '0;
    else if (tick_i && cnt_q != {CW{1'b1}}) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pend_o = (cnt_q >= period_i);
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NSRC = 2,
  parameter int PW   = 3,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0][PW-1:0] pri_i,
  input  logic [NSRC-1:0]         pend_i,
  input  logic [NSRC-1:0]         vec_ok_i,
  input  logic [PW-1:0]           mask_i,
  output logic                    take_o,
  output logic [IDW-1:0]          src_o
);
  logic [NSRC-1:0] cand;

  for (genvar g = 0; g < NSRC; g++) begin : g_cand
    assign cand[g] = pend_i[g] & vec_ok_i[g];
  end

  logic          found;
  logic [PW-1:0] best;

  always_comb begin
    found = 1'b0;
    best  = '0;
    src_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!found || pri_i[i] > best)) begin
        found = 1'b1;
        best  = pri_i[i];
        src_o = IDW'(i);
      end
    end
    take_o = found && (best > mask_i);
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import intr_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int IDW = 1,
  parameter int DPW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_i,
  input  logic           rti_i,
  input  logic           take_i,
  input  logic [IDW-1:0] src_i,
  input  logic [AW-1:0]  sp_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [DW-1:0]  sr_i,
  input  logic [DW-1:0]  rdata_i,
  input  logic [AW-1:0]  vec_tgt_i,
  output logic           entry_go_o,
  output logic [IDW-1:0] sel_o,
  output logic           mem_wr_o,
  output logic           mem_rd_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           pc_load_o,
  output logic [AW-1:0]  pc_o,
  output logic           sr_load_o,
  output logic [DW-1:0]  sr_o,
  output logic           sp_load_o,
  output logic [AW-1:0]  sp_o,
  output logic           in_handler_o,
  output logic           busy_o
);
  localparam logic [AW-1:0] WSTEP = AW'(2);

  seq_st_e        st_q, st_d;
  logic [AW-1:0]  sp_q, sp_d, pc_q, pc_d;
  logic [DW-1:0]  sr_q, sr_d;
  logic [IDW-1:0] sel_q, sel_d;
  logic [DPW-1:0] dep_q, dep_d;
  logic           idle, ret_go;

  assign idle       = (st_q == ST_IDLE);
  assign ret_go     = step_i && idle && rti_i && (dep_q != '0);
  assign entry_go_o = step_i && idle && (dep_q == '0) && take_i;

  always_comb begin
    st_d  = st_q;
    sp_d  = sp_q;
    pc_d  = pc_q;
    sr_d  = sr_q;
    sel_d = sel_q;
    dep_d = dep_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ret_go) begin
          sp_d = sp_i;
          st_d = ST_POP_PC;
        end else if (entry_go_o) begin
          sp_d  = sp_i;
          pc_d  = pc_i;
          sr_d  = sr_i;
          sel_d = src_i;
          st_d  = ST_PUSH_SR;
        end
      end
      ST_PUSH_SR: begin
        sp_d = sp_q - WSTEP;
        st_d = ST_PUSH_PC;
      end
      ST_PUSH_PC: begin
        sp_d = sp_q - WSTEP;
        st_d = ST_LOAD;
      end
      ST_LOAD: begin
        dep_d = dep_q + DPW'(1);
        st_d  = ST_IDLE;
      end
      ST_POP_PC: begin
        pc_d = rdata_i;
        sp_d = sp_q + WSTEP;
        st_d = ST_POP_SR;
      end
      ST_POP_SR: begin
        sr_d = rdata_i;
        sp_d = sp_q + WSTEP;
        st_d = ST_FIN;
      end
      ST_FIN: begin
        dep_d = dep_q - DPW'(1);
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sp_q  <= '0;
      pc_q  <= '0;
      sr_q  <= '0;
      sel_q <= '0;
      dep_q <= '0;
    end else begin
      st_q  <= st_d;
      sp_q  <= sp_d;
      pc_q  <= pc_d;
      sr_q  <= sr_d;
      sel_q <= sel_d;
      dep_q <= dep_d;
    end
  end

  assign mem_wr_o     = (st_q == ST_PUSH_SR) || (st_q == ST_PUSH_PC);
  assign mem_rd_o     = (st_q == ST_POP_PC) || (st_q == ST_POP_SR);
  assign mem_addr_o   = mem_wr_o ? (sp_q - WSTEP) : sp_q;
  assign mem_wdata_o  = (st_q == ST_PUSH_SR) ? sr_q : pc_q;
  assign pc_load_o    = (st_q == ST_LOAD) || (st_q == ST_FIN);
  assign pc_o         = (st_q == ST_LOAD) ? vec_tgt_i : pc_q;
  assign sr_load_o    = (st_q == ST_FIN);
  assign sr_o         = sr_q;
  assign sp_load_o    = pc_load_o;
  assign sp_o         = sp_q;
  assign sel_o        = sel_q;
  assign in_handler_o = (dep_q != '0);
  assign busy_o       = !idle;
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
  import intr_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int PW       = 3,
  parameter int CW       = 12,
  parameter int TX_DELAY = 2,
  parameter int PRI_LSB  = 4,
  parameter int MASK_LSB = 8,
  parameter int TIE_BIT  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          rti_i,
  input  logic [DW-1:0] sr_i,
  input  logic [7:0]    pri_ser_i,
  input  logic [7:0]    pri_tmr_i,
  input  logic [7:0]    scr_i,
  input  logic          tdr_wr_i,
  input  logic [CW-1:0] period_i,
  input  logic [1:0]    vec_ok_i,
  input  logic [AW-1:0] vec_tgt_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          vec_sel_o,
  output logic          mem_wr_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o,
  output logic          sr_load_o,
  output logic [DW-1:0] sr_o,
  output logic          sp_load_o,
  output logic [AW-1:0] sp_o,
  output logic          in_handler_o,
  output logic          busy_o
);
  localparam int IDW = 1;

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic                    txe, tmr_pend, take, entry_go, tmr_clr;
  logic [IDW-1:0]          pick_src;
  logic [NSRC-1:0][PW-1:0] pri_v;
  logic [NSRC-1:0]         pend_v;

  assign pri_v[SRC_SER]  = pri_ser_i[PRI_LSB +: PW];
  assign pri_v[SRC_TMR]  = pri_tmr_i[PRI_LSB +: PW];
  assign pend_v[SRC_SER] = scr_i[TIE_BIT] & txe;
  assign pend_v[SRC_TMR] = tmr_pend;
  assign tmr_clr         = entry_go && (pick_src == IDW'(SRC_TMR));

  txe_tracker #(.DELAY(TX_DELAY)) u_txe (
    .clk(clk), .rst_n(rst_s_n), .wr_i(tdr_wr_i), .tick_i(step_i), .empty_o(txe)
  );

  step_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .tick_i(step_i), .clr_i(tmr_clr),
    .period_i(period_i), .pend_o(tmr_pend)
  );

  prio_pick #(.NSRC(NSRC), .PW(PW)) u_pick (
    .pri_i(pri_v), .pend_i(pend_v), .vec_ok_i(vec_ok_i),
    .mask_i(sr_i[MASK_LSB +: PW]), .take_o(take), .src_o(pick_src)
  );

  stack_seq #(.AW(AW), .DW(DW), .IDW(IDW), .DPW(2)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .step_i(step_i), .rti_i(rti_i),
    .take_i(take), .src_i(pick_src), .sp_i(sp_i), .pc_i(pc_i), .sr_i(sr_i),
    .rdata_i(mem_rdata_i), .vec_tgt_i(vec_tgt_i), .entry_go_o(entry_go),
    .sel_o(vec_sel_o), .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .pc_load_o(pc_load_o), .pc_o(pc_o), .sr_load_o(sr_load_o), .sr_o(sr_o),
    .sp_load_o(sp_load_o), .sp_o(sp_o), .in_handler_o(in_handler_o),
    .busy_o(busy_o)
  );
endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        step_i,
  input logic        rti_i,
  input logic [7:0]  pri_ser_i,
  input logic [7:0]  pri_tmr_i,
  input logic        vec_sel_o,
  input logic        mem_wr_o,
  input logic        mem_rd_o,
  input logic [15:0] mem_addr_o,
  input logic [15:0] mem_wdata_o,
  input logic        pc_load_o,
  input logic        sr_load_o,
  input logic        in_handler_o,
  input logic        busy_o
);
  // R7
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr_o, mem_rd_o, pc_load_o}));

  // R7
  push_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && $past(mem_wr_o)) |-> (mem_addr_o == $past(mem_addr_o) - 16'd2));

  // R10
  pop_asc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 16'd2));

  // R2
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && !$past(mem_wr_o)) |->
      ((vec_sel_o ? pri_tmr_i[6:4] : pri_ser_i[6:4]) > mem_wdata_o[10:8]));

  // R7
  vec_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && !sr_load_o) |-> $past(mem_wr_o));

  // R9
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_handler_o && !busy_o && step_i && !rti_i) |=> !mem_wr_o);
endmodule

bind intr_dispatch intr_dispatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .rti_i(rti_i),
  .pri_ser_i(pri_ser_i), .pri_tmr_i(pri_tmr_i), .vec_sel_o(vec_sel_o),
  .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .pc_load_o(pc_load_o), .sr_load_o(sr_load_o),
  .in_handler_o(in_handler_o), .busy_o(busy_o)
);

// File: tb/tb_intr_dispatch.sv
module tb_intr_dispatch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0, rti_i = 1'b0, tdr_wr_i = 1'b0;
  logic [15:0] sr_i = '0, sp_i = 16'h0400, pc_i = 16'h1234;
  logic [7:0]  pri_ser_i = '0, pri_tmr_i = '0, scr_i = '0;
  logic [11:0] period_i = '0;
  logic [1:0]  vec_ok_i = '0;
  logic [15:0] vec_tgt_i, mem_rdata_i;
  logic        vec_sel_o, mem_wr_o, mem_rd_o, pc_load_o, sr_load_o, sp_load_o;
  logic        in_handler_o, busy_o;
  logic [15:0] mem_addr_o, mem_wdata_o, pc_o, sr_o, sp_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign mem_rdata_i = mem_addr_o ^ 16'h5A3C;
  assign vec_tgt_i   = vec_sel_o ? 16'h2400 : 16'h1800;

  intr_dispatch dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .rti_i(rti_i), .sr_i(sr_i),
    .pri_ser_i(pri_ser_i), .pri_tmr_i(pri_tmr_i), .scr_i(scr_i),
    .tdr_wr_i(tdr_wr_i), .period_i(period_i), .vec_ok_i(vec_ok_i),
    .vec_tgt_i(vec_tgt_i), .sp_i(sp_i), .pc_i(pc_i), .mem_rdata_i(mem_rdata_i),
    .vec_sel_o(vec_sel_o), .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .pc_load_o(pc_load_o),
    .pc_o(pc_o), .sr_load_o(sr_load_o), .sr_o(sr_o), .sp_load_o(sp_load_o),
    .sp_o(sp_o), .in_handler_o(in_handler_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input bit rti);
    rti_i  = rti;
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    rti_i  = 1'b0;
  endtask

  task automatic finish_entry();
    repeat (3) @(negedge clk);
  endtask

  task automatic unwind();
    step(1'b1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: quiet after reset
    chk(!mem_wr_o && !mem_rd_o && !pc_load_o && !sr_load_o, "R1 no requests",
        {mem_wr_o, mem_rd_o, pc_load_o}, 0);
    chk(!in_handler_o && !busy_o, "R1 idle", {in_handler_o, busy_o}, 0);

    // R11: everything pending, no strobe
    scr_i = 8'h80; vec_ok_i = 2'b11; pri_ser_i = 8'h50; pri_tmr_i = 8'h60;
    repeat (5) @(negedge clk);
    chk(!mem_wr_o && !busy_o, "R11 no strobe no entry", mem_wr_o, 0);
    // R1: empty flag set at reset, so serial alone is accepted
    vec_ok_i = 2'b01;
    step(1'b0);
    chk(mem_wr_o && vec_sel_o == 1'b0, "R1 empty flag set", mem_wr_o, 1);
    finish_entry();
    unwind();

    // R7 / R9 / R10 directed entry and return
    do_reset();
    scr_i = 8'h80; vec_ok_i = 2'b01; pri_ser_i = 8'h30;
    sr_i = 16'h01A5; sp_i = 16'h0400; pc_i = 16'hBEEF;
    step(1'b0);
    chk(mem_wr_o && mem_addr_o == 16'h03FE, "R7 sr addr", mem_addr_o, 16'h03FE);
    chk(mem_wdata_o == 16'h01A5, "R7 sr data", mem_wdata_o, 16'h01A5);
    @(negedge clk);
    chk(mem_wr_o && mem_addr_o == 16'h03FC, "R7 pc addr", mem_addr_o, 16'h03FC);
    chk(mem_wdata_o == 16'hBEEF, "R7 pc data", mem_wdata_o, 16'hBEEF);
    @(negedge clk);
    chk(pc_load_o && sp_load_o && !sr_load_o && !mem_wr_o, "R7 load strobes",
        {pc_load_o, sp_load_o, sr_load_o}, 3'b110);
    chk(pc_o == 16'h1800, "R7 vector pc", pc_o, 16'h1800);
    chk(sp_o == 16'h03FC, "R7 new sp", sp_o, 16'h03FC);
    @(negedge clk);
    chk(in_handler_o && !busy_o, "R9 handler active", in_handler_o, 1);
    step(1'b0);
    chk(!mem_wr_o && !busy_o, "R9 lockout", mem_wr_o, 0);
    sp_i = 16'h03FC;
    step(1'b1);
    chk(mem_rd_o && mem_addr_o == 16'h03FC, "R10 pop pc addr", mem_addr_o, 16'h03FC);
    @(negedge clk);
    chk(mem_rd_o && mem_addr_o == 16'h03FE, "R10 pop sr addr", mem_addr_o, 16'h03FE);
    @(negedge clk);
    chk(pc_load_o && sr_load_o && sp_load_o, "R10 strobes",
        {pc_load_o, sr_load_o, sp_load_o}, 3'b111);
    chk(pc_o == (16'h03FC ^ 16'h5A3C), "R10 pc", pc_o, 16'h03FC ^ 16'h5A3C);
    chk(sr_o == (16'h03FE ^ 16'h5A3C), "R10 sr", sr_o, 16'h03FE ^ 16'h5A3C);
    chk(sp_o == 16'h0400, "R10 sp", sp_o, 16'h0400);
    @(negedge clk);
    chk(!in_handler_o, "R10 handler cleared", in_handler_o, 0);
    sr_i = 16'h0000; sp_i = 16'h0400;

    // R4: enable bit clear blocks serial
    scr_i = 8'h00;
    step(1'b0);
    chk(!mem_wr_o, "R4 enable clear", mem_wr_o, 0);
    scr_i = 8'h80;

    // R5: empty flag countdown after data write
    tdr_wr_i = 1'b1; @(negedge clk); tdr_wr_i = 1'b0;
    step(1'b0);
    chk(!mem_wr_o, "R5 strobe1 blocked", mem_wr_o, 0);
    step(1'b0);
    chk(!mem_wr_o, "R5 strobe2 blocked", mem_wr_o, 0);
    step(1'b0);
    chk(mem_wr_o, "R5 strobe3 taken", mem_wr_o, 1);
    finish_entry();
    unwind();

    // R6: timer period counting and clear on accept
    do_reset();
    scr_i = 8'h00; vec_ok_i = 2'b10; pri_tmr_i = 8'h40; period_i = 12'd3;
    for (int k = 0; k < 3; k++) begin
      step(1'b0);
      chk(!mem_wr_o, "R6 below period", mem_wr_o, 0);
    end
    step(1'b0);
    chk(mem_wr_o && vec_sel_o, "R6 at period", {mem_wr_o, vec_sel_o}, 2'b11);
    finish_entry();
    unwind();
    step(1'b0);
    chk(!mem_wr_o, "R6 cleared after accept a", mem_wr_o, 0);
    step(1'b0);
    chk(!mem_wr_o, "R6 cleared after accept b", mem_wr_o, 0);
    step(1'b0);
    chk(mem_wr_o, "R6 period again", mem_wr_o, 1);
    finish_entry();
    unwind();
    sr_i = 16'h0700;
    repeat (6) step(1'b0);
    chk(!mem_wr_o, "R6 masked", mem_wr_o, 0);
    sr_i = 16'h0000;
    step(1'b0);
    chk(mem_wr_o, "R6 blocked stays pending", mem_wr_o, 1);
    finish_entry();
    unwind();

    // R2 R3 R8 sweep: both pending, period 0
    do_reset();
    scr_i = 8'h80; period_i = 12'd0;
    for (int vp = 0; vp < 4; vp++) begin
      for (int ps = 0; ps < 8; ps++) begin
        for (int pt = 0; pt < 8; pt++) begin
          for (int m = 0; m < 8; m++) begin
            bit cs, ct, win_t, acc;
            int wp;
            vec_ok_i  = 2'(vp);
            pri_ser_i = {1'b1, 3'(ps), 4'hF};
            pri_tmr_i = {1'b0, 3'(pt), 4'hA};
            sr_i      = {5'b10101, 3'(m), 8'h3C};
            cs = vp[0]; ct = vp[1];
            win_t = ct && (!cs || pt > ps);
            wp = win_t ? pt : ps;
            acc = (cs || ct) && (wp > m);
            step(1'b0);
            chk(mem_wr_o == acc, "R2 R8 accept", mem_wr_o, acc);
            if (acc) begin
              chk(vec_sel_o == win_t, "R3 winner", vec_sel_o, win_t);
              finish_entry();
              unwind();
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule